// File: doc/BRIEF.md
# Microcoded Accumulator Processor Core

This block is a small processor built around a single 16-bit accumulator. It holds a program counter, an instruction register, an accumulator, a B register that latches memory operands, and three compare flags. Sequencing is done by a micro-program counter. The micro-program counter steps through control words, and each control word raises only the strobes needed in that cycle, such as memory read, instruction-register load or PC increment. Every instruction starts with a shared fetch routine at micro-address 0. A decode step then maps the 4-bit opcode to the first micro-address of that opcode's execute routine. The last step of each execute routine returns control to fetch.

The core talks to one synchronous memory through an address port, a write-data port, a read-data port and separate read and write enables. Read data is expected on the cycle after the read enable. There is also one input port and one output port, each with a one-cycle strobe. A halt instruction parks the core until reset.

Top module: `acc_cpu`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the core drives a memory read at address 0. Reset clears the PC, the accumulator, the three compare flags and the halted output.
- R2: An instruction word has the opcode in bits [15:12] and a 12-bit operand in bits [11:0]. The fetch reads memory at the PC and increments the PC. Fetch and decode take three cycles, so an HLT placed at address 0 raises `halted` on the third clock edge after reset is released.
- R3: Opcodes are 0 NOP, 1 LDA, 2 STA, 3 ADD, 4 SUB, 5 IN, 6 OUT, 7 JMP, 8 JN, 9 HLT, A CMP, B JG, C JE and D JL. Opcodes E and F, like NOP, change nothing.
- R4: LDA loads the accumulator from memory at the operand address. STA writes the accumulator to that address in one single-cycle write.
- R5: ADD and SUB add the memory operand to the accumulator, or subtract it from the accumulator, modulo 2^16. The result goes back into the accumulator.
- R6: IN loads the accumulator from `in_data` and pulses `in_strobe` for one cycle. OUT presents the accumulator on `out_data` with a one-cycle `out_strobe`.
- R7: JMP always continues execution at the operand address.
- R8: JN jumps only when accumulator bit 15 is 1. When the jump is not taken, execution continues at the next word.
- R9: CMP compares the accumulator with the memory operand as unsigned values. It sets exactly one of the flags greater, equal and less, and it leaves the accumulator unchanged. No other instruction changes the flags.
- R10: JG, JE and JL jump when the greater, equal or less flag is set, respectively. When they do not jump, execution falls through to the next word.
- R11: After HLT, `halted` stays at 1 and no memory read or write occurs until reset.
- R12: `mem_rd` and `mem_wr` are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Memory word address |
| mem_rdata | input | 16 | Memory read data, valid the cycle after mem_rd |
| mem_wdata | output | 16 | Memory write data (accumulator) |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| in_data | input | 16 | Input port value |
| in_strobe | output | 1 | One-cycle pulse when IN samples in_data |
| out_data | output | 16 | Output port value (accumulator) |
| out_strobe | output | 1 | One-cycle pulse marking an OUT |
| halted | output | 1 | Core has executed HLT |

## Verification
Each short program is run to its HLT, and the result is read back from the memory model. The arithmetic program uses an addition that wraps past 0xFFFF and a subtraction that goes below zero, so it catches a carry or borrow that is dropped or kept wrongly. The compare program is run three times, once for each ordering of its operands. One of those runs uses 0x8000 against 0x0001, which separates an unsigned compare from a signed one. The JG, JE, JL ladder then shows which single flag was set. Jump programs place sentinel stores on both the taken path and the skipped path, and a HLT at address 0 pins down how many cycles fetch and decode take.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-5:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic [DW-1:0] in_data,
  output logic          in_strobe,
  output logic [DW-1:0] out_data,
  output logic          out_strobe,
  output logic          halted
);
  localparam int AW = DW - 4;
  localparam int UW = 5;
  localparam logic [AW-1:0] PC_ONE = 1;

  localparam logic [UW-1:0] U_F0 = 5'd0, U_F1 = 5'd1, U_DEC = 5'd2, U_NOP = 5'd3,
    U_LDA0 = 5'd4, U_LDA1 = 5'd5, U_LDA2 = 5'd6, U_STA = 5'd7,
    U_ADD0 = 5'd8, U_ADD1 = 5'd9, U_ADD2 = 5'd10,
    U_SUB0 = 5'd11, U_SUB1 = 5'd12, U_SUB2 = 5'd13,
    U_IN = 5'd14, U_OUT = 5'd15, U_JMP = 5'd16, U_JN = 5'd17, U_HLT = 5'd18,
    U_CMP0 = 5'd19, U_CMP1 = 5'd20, U_CMP2 = 5'd21,
    U_JG = 5'd22, U_JE = 5'd23, U_JL = 5'd24;

  typedef enum logic [2:0] {A_HOLD, A_B, A_ADD, A_SUB, A_IN} acc_op_t;

  logic [UW-1:0] upc, upc_nx;
  logic [AW-1:0] pc;
  logic [DW-1:0] ir, acc, breg;
  logic          fg, fe, fl;

  logic    use_ir, rd, wr, ir_ld, pc_inc, dec, b_ld, outs, ins, cmp_en, jmp, fin, hold;
  acc_op_t acc_op;

  function automatic logic [UW-1:0] start_of(input logic [3:0] op);
    case (op)
      4'h1: start_of = U_LDA0;
      4'h2: start_of = U_STA;
      4'h3: start_of = U_ADD0;
      4'h4: start_of = U_SUB0;
      4'h5: start_of = U_IN;
      4'h6: start_of = U_OUT;
      4'h7: start_of = U_JMP;
      4'h8: start_of = U_JN;
      4'h9: start_of = U_HLT;
      4'hA: start_of = U_CMP0;
      4'hB: start_of = U_JG;
      4'hC: start_of = U_JE;
      4'hD: start_of = U_JL;
      default: start_of = U_NOP;
    endcase
  endfunction

  always_comb begin
    use_ir = 1'b0; rd = 1'b0; wr = 1'b0; ir_ld = 1'b0; pc_inc = 1'b0; dec = 1'b0;
    b_ld = 1'b0; outs = 1'b0; ins = 1'b0; cmp_en = 1'b0; jmp = 1'b0; fin = 1'b0;
    hold = 1'b0; acc_op = A_HOLD;
    case (upc)
      U_F0:  rd = 1'b1;
      U_F1:  begin ir_ld = 1'b1; pc_inc = 1'b1; end
      U_DEC: dec = 1'b1;
      U_LDA0, U_ADD0, U_SUB0, U_CMP0: begin use_ir = 1'b1; rd = 1'b1; end
      U_LDA1, U_ADD1, U_SUB1, U_CMP1: b_ld = 1'b1;
      U_LDA2: begin acc_op = A_B;   fin = 1'b1; end
      U_ADD2: begin acc_op = A_ADD; fin = 1'b1; end
      U_SUB2: begin acc_op = A_SUB; fin = 1'b1; end
      U_CMP2: begin cmp_en = 1'b1;  fin = 1'b1; end
      U_STA:  begin use_ir = 1'b1; wr = 1'b1; fin = 1'b1; end
      U_IN:   begin acc_op = A_IN; ins = 1'b1; fin = 1'b1; end
      U_OUT:  begin outs = 1'b1; fin = 1'b1; end
      U_JMP:  begin jmp = 1'b1; fin = 1'b1; end
      U_JN:   begin jmp = acc[DW-1]; fin = 1'b1; end
      U_JG:   begin jmp = fg; fin = 1'b1; end
      U_JE:   begin jmp = fe; fin = 1'b1; end
      U_JL:   begin jmp = fl; fin = 1'b1; end
      U_HLT:  hold = 1'b1;
      default: fin = 1'b1;
    endcase
  end

  always_comb begin
    if (dec)       upc_nx = start_of(ir[DW-1:DW-4]);
    else if (fin)  upc_nx = U_F0;
    else if (hold) upc_nx = upc;
    else           upc_nx = upc + 5'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upc <= U_F0; pc <= '0; ir <= '0; acc <= '0; breg <= '0;
      fg <= 1'b0; fe <= 1'b0; fl <= 1'b0;
    end else begin
      upc <= upc_nx;
      if (ir_ld) ir <= mem_rdata;
      if (b_ld) breg <= mem_rdata;
      if (jmp) pc <= ir[AW-1:0];
      else if (pc_inc) pc <= pc + PC_ONE;
      case (acc_op)
        A_B:     acc <= breg;
        A_ADD:   acc <= acc + breg;
        A_SUB:   acc <= acc - breg;
        A_IN:    acc <= in_data;
        default: ;
      endcase
      if (cmp_en) begin
        fg <= acc > breg;
        fe <= acc == breg;
        fl <= acc < breg;
      end
    end
  end

  assign mem_addr   = use_ir ? ir[AW-1:0] : pc;
  assign mem_rd     = rd;
  assign mem_wr     = wr;
  assign mem_wdata  = acc;
  assign in_strobe  = ins;
  assign out_strobe = outs;
  assign out_data   = acc;
  assign halted     = hold;

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr)); // R12
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n) (upc == U_F1) |=> (pc == $past(pc) + PC_ONE)); // R2
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) halted |=> (halted && !mem_rd && !mem_wr)); // R11
  AST_CMP_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n) cmp_en |=> $onehot({fg, fe, fl})); // R9
  AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n) cmp_en |=> $stable(acc)); // R9
  AST_STORE_ADDR: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> (mem_addr == ir[AW-1:0] && mem_wdata == acc)); // R4
  AST_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n) in_strobe |=> (acc == $past(in_data))); // R6
endmodule

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic [15:0] mem_wdata;
  logic        mem_rd, mem_wr;
  logic [15:0] in_data = 16'h0000;
  logic        in_strobe;
  logic [15:0] out_data;
  logic        out_strobe;
  logic        halted;

  logic        ld_en = 1'b0;
  logic [7:0]  ld_a = '0;
  logic [15:0] ld_d = '0;
  logic [15:0] mem [0:255];

  int nchk = 0, nfail = 0;
  int ins_cnt = 0, outs_cnt = 0, ovl_cnt = 0, hacc_cnt = 0;
  logic [15:0] last_out = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu u_dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .in_data(in_data),
    .in_strobe(in_strobe), .out_data(out_data), .out_strobe(out_strobe), .halted(halted)
  );

  always @(posedge clk) begin
    if (ld_en) mem[ld_a] <= ld_d;
    else if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
  end

  always @(negedge clk) if (rst_n) begin
    if (in_strobe) ins_cnt <= ins_cnt + 1;
    if (out_strobe) begin outs_cnt <= outs_cnt + 1; last_out <= out_data; end
    if (mem_rd && mem_wr) ovl_cnt <= ovl_cnt + 1;
    if (halted && (mem_rd || mem_wr)) hacc_cnt <= hacc_cnt + 1;
  end

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
    return {op, a};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] a, input logic [15:0] d);
    ld_en = 1'b1; ld_a = a; ld_d = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic begin_prog();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic run(input string req);
    int n = 0;
    rst_n = 1'b1;
    while (!halted && n < 2000) begin @(negedge clk); n++; end
    chk({req, " reached HLT"}, {31'd0, halted}, 32'd1);
  endtask

  task automatic t_timing();
    begin_prog();
    put(8'h00, ins(4'h9, 12'h000));
    rst_n = 1'b1;
    chk("R1 read at reset addr", {20'd0, mem_addr}, 32'd0);
    chk("R1 read enable after reset", {31'd0, mem_rd}, 32'd1);
    chk("R1 halted clear", {31'd0, halted}, 32'd0);
    repeat (2) @(negedge clk);
    chk("R2 not halted after 2 edges", {31'd0, halted}, 32'd0);
    @(negedge clk);
    chk("R2 halted after 3 edges", {31'd0, halted}, 32'd1);
  endtask

  task automatic t_arith();
    begin_prog();
    put(8'h00, ins(4'h1, 12'h080));
    put(8'h01, ins(4'h3, 12'h081));
    put(8'h02, ins(4'h2, 12'h090));
    put(8'h03, ins(4'h4, 12'h082));
    put(8'h04, ins(4'h2, 12'h091));
    put(8'h05, ins(4'h9, 12'h000));
    put(8'h80, 16'h0005); put(8'h81, 16'hFFFF); put(8'h82, 16'h0007);
    put(8'h90, 16'hDEAD); put(8'h91, 16'hDEAD);
    run("R5 arith");
    chk("R5 ADD wraps", {16'd0, mem[8'h90]}, 32'h0004);
    chk("R5 SUB borrows", {16'd0, mem[8'h91]}, 32'hFFFD);
    chk("R4 operand untouched", {16'd0, mem[8'h80]}, 32'h0005);
  endtask

  task automatic t_io();
    int i0, o0;
    begin_prog();
    put(8'h00, ins(4'h5, 12'h000));
    put(8'h01, ins(4'h6, 12'h000));
    put(8'h02, ins(4'h2, 12'h090));
    put(8'h03, ins(4'h9, 12'h000));
    put(8'h90, 16'hDEAD);
    in_data = 16'h1234;
    i0 = ins_cnt; o0 = outs_cnt;
    run("R6 io");
    in_data = 16'h0000;
    chk("R6 one in strobe", ins_cnt - i0, 32'd1);
    chk("R6 one out strobe", outs_cnt - o0, 32'd1);
    chk("R6 out value", {16'd0, last_out}, 32'h1234);
    chk("R4 STA of IN value", {16'd0, mem[8'h90]}, 32'h1234);
  endtask

  task automatic t_jumps();
    begin_prog();
    put(8'h00, ins(4'h1, 12'h080));
    put(8'h01, ins(4'h8, 12'h003));
    put(8'h02, ins(4'h2, 12'h090));
    put(8'h03, ins(4'h1, 12'h081));
    put(8'h04, ins(4'h8, 12'h006));
    put(8'h05, ins(4'h2, 12'h091));
    put(8'h06, ins(4'h7, 12'h008));
    put(8'h07, ins(4'h2, 12'h092));
    put(8'h08, ins(4'h9, 12'h000));
    put(8'h80, 16'h8000); put(8'h81, 16'h0001);
    put(8'h90, 16'hDEAD); put(8'h91, 16'hDEAD); put(8'h92, 16'hDEAD);
    run("R7 jumps");
    chk("R8 JN taken skips store", {16'd0, mem[8'h90]}, 32'hDEAD);
    chk("R8 JN not taken falls through", {16'd0, mem[8'h91]}, 32'h0001);
    chk("R7 JMP skips store", {16'd0, mem[8'h92]}, 32'hDEAD);
  endtask

  task automatic t_cmp(input logic [15:0] a, input logic [15:0] b, input int slot);
    begin_prog();
    put(8'h00, ins(4'h1, 12'h080));
    put(8'h01, ins(4'hA, 12'h081));
    put(8'h02, ins(4'hB, 12'h006));
    put(8'h03, ins(4'hC, 12'h008));
    put(8'h04, ins(4'hD, 12'h00A));
    put(8'h05, ins(4'h9, 12'h000));
    put(8'h06, ins(4'h2, 12'h090));
    put(8'h07, ins(4'h9, 12'h000));
    put(8'h08, ins(4'h2, 12'h091));
    put(8'h09, ins(4'h9, 12'h000));
    put(8'h0A, ins(4'h2, 12'h092));
    put(8'h0B, ins(4'h9, 12'h000));
    put(8'h80, a); put(8'h81, b);
    put(8'h90, 16'hDEAD); put(8'h91, 16'hDEAD); put(8'h92, 16'hDEAD);
    run("R10 compare ladder");
    for (int k = 0; k < 3; k++) begin
      if (k == slot) chk("R9 R10 taken branch stores unchanged ACC", {16'd0, mem[8'h90 + k]}, {16'd0, a});
      else chk("R10 other branches not taken", {16'd0, mem[8'h90 + k]}, 32'hDEAD);
    end
  endtask

  task automatic t_unused();
    begin_prog();
    put(8'h00, ins(4'h0, 12'h090));
    put(8'h01, ins(4'hE, 12'h090));
    put(8'h02, ins(4'hF, 12'h090));
    put(8'h03, ins(4'h1, 12'h080));
    put(8'h04, ins(4'h2, 12'h091));
    put(8'h05, ins(4'h9, 12'h000));
    put(8'h80, 16'h00A5); put(8'h90, 16'hBEEF); put(8'h91, 16'hDEAD);
    run("R3 unused opcodes");
    chk("R3 NOP/E/F write nothing", {16'd0, mem[8'h90]}, 32'hBEEF);
    chk("R3 execution continues", {16'd0, mem[8'h91]}, 32'h00A5);
  endtask

  task automatic t_reset_clears();
    begin_prog();
    put(8'h00, ins(4'hB, 12'h004));
    put(8'h01, ins(4'hC, 12'h004));
    put(8'h02, ins(4'hD, 12'h004));
    put(8'h03, ins(4'h2, 12'h090));
    put(8'h04, ins(4'h9, 12'h000));
    put(8'h90, 16'hDEAD);
    chk("R1 ACC cleared in reset", {16'd0, out_data}, 32'h0000);
    run("R1 reset clears flags");
    chk("R1 R9 flags cleared, ACC zero stored", {16'd0, mem[8'h90]}, 32'h0000);
  endtask

  task automatic t_halt_quiet();
    int h0;
    h0 = hacc_cnt;
    repeat (20) @(negedge clk);
    chk("R11 halted held", {31'd0, halted}, 32'd1);
    chk("R11 no memory access while halted", hacc_cnt - h0, 32'd0);
  endtask

  task automatic finish_up(input int extra);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk + extra, nfail + extra);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    $display("FAIL watchdog expired");
    finish_up(1);
  end

  initial begin
    t_timing();
    t_arith();
    t_io();
    t_jumps();
    t_cmp(16'h8000, 16'h0001, 0);
    t_cmp(16'h4321, 16'h4321, 1);
    t_cmp(16'h0002, 16'hFFFE, 2);
    t_reset_clears();
    t_unused();
    t_halt_quiet();
    chk("R12 no simultaneous read and write", ovl_cnt, 32'd0);
    finish_up(0);
  end
endmodule